// File: doc/BRIEF.md
# Multichannel ADC Conversion Sequencer

This block is the digital controller that sits in front of an eight-slot analog-to-digital converter. For each slot it picks the input channel, sends the converter a one-cycle start pulse, and waits for the converter's done pulse. That done pulse carries a conversion result and a comparator decision. The block stores the result in the result register for that slot and stores the comparator decision in the matching bit of a compare register. When the last slot finishes, it raises a flag, and this flag can drive an interrupt request.

Software programs a small control register with these fields: an enable, a trigger source, an input mode and a channel select. It clears the end-of-cycle flag through the same register.

The trigger source has two settings:
- **Internal:** the block converts continuously, one full cycle after another.
- **External:** each full cycle waits for a falling edge on a trigger pin. The pin is sampled on a machine-cycle tick.

The input mode also has two settings:
- **Scan:** each channel is converted into its own slot.
- **Select:** one chosen low channel is converted four times into slots 0 to 3, and then channels 4 to 7 are converted.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, `ctl_rdata`, `cmp_bits`, `irq` and `conv_start` are all 0. The control register layout is: bit 0 end-of-cycle flag, bit 1 enable, bits 3:2 channel select, bit 4 select-mode, bit 5 external-trigger.
- R2: With enable=1 and external-trigger=0, no start is issued before the first machine-cycle tick. The first start appears in the clock cycle after that tick and targets slot 0. When slot 7 completes, slot 0 starts again without waiting for a tick. Every `conv_start` is a single-cycle pulse.
- R3: While enable=0, no start is issued. A done pulse that belongs to a conversion started before enable was cleared is discarded, and it leaves its result register unchanged.
- R4: In external mode, `trig_pin` is sampled only on ticks. An edge is recognised only when the pin reads high at one tick and low at the next. A low pulse that falls between two ticks starts nothing. An edge seen while enable=0 starts nothing.
- R5: After a recognised edge, slots 0 to 7 are converted once: exactly eight starts. The flag is then set, and no further start is issued until a new edge arrives.
- R6: A falling edge that occurs while a cycle is in progress is ignored.
- R7: In scan mode, slot i converts channel i, in ascending order. Its result is then readable at `rd_idx` = i.
- R8: In select mode, slots 0 to 3 each convert the channel numbered by the channel-select field (values 0 to 3). Slots 4 to 7 convert channels 4 to 7.
- R9: The flag is set when slot 7 completes. `irq` is high one cycle after the flag is 1 while `irq_en` is 1, and it stays low while `irq_en` is 0.
- R10: When a slot completes, `cmp_bits[slot]` takes the comparator bit (1 means the input is above the reference). Compare bits change only on a completion.
- R11: The results of a new cycle overwrite the results of the previous one. `rd_data` shows the register selected by `rd_idx` one clock after `rd_idx` is presented.
- R12: Writing 0 to the flag bit clears the flag. Writing 1 to the flag bit does not set it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mc_tick | input | 1 | Machine-cycle tick, one clock wide |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 6 | Control register write value |
| ctl_rdata | output | 6 | Control register contents |
| irq_en | input | 1 | Interrupt enable |
| irq | output | 1 | Interrupt request |
| trig_pin | input | 1 | External trigger pin (synchronous to `clk`) |
| conv_start | output | 1 | Start pulse to the converter |
| conv_chan | output | 3 | Channel for the conversion being started |
| conv_done | input | 1 | Converter done pulse |
| conv_data | input | 10 | Conversion result, valid with `conv_done` |
| conv_gt | input | 1 | Comparator result, valid with `conv_done` |
| rd_idx | input | 3 | Result register read index |
| rd_data | output | 10 | Result register read data, one clock latency |
| cmp_bits | output | 8 | Compare register |

## Verification
The assertions are checked on every cycle and cover these rules:
- `conv_start` is a one-cycle pulse.
- No start is issued while the block is disabled.
- No start is issued in external mode while idle with no edge pending.
- A trigger is never pending while a cycle is busy.
- Slots 4 to 7 always drive their own channel.
- The flag rises only on a done pulse.
- Compare bits hold between completions.

Some behaviour can only be shown by the bench's scenarios:
- The exact sequence of channels over whole cycles in scan mode and in every select value.
- The stored results and their overwrite by a later cycle.
- Rejection of glitches and of mid-cycle edges.
- Discarding of a done pulse after disable.
- The first start after the first tick.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;

  // Bit positions of the control register fields. The channel-select
  // field starts at CTL_SEL_LSB; the mode bits follow it.
  localparam int CTL_FLAG    = 0;
  localparam int CTL_EN      = 1;
  localparam int CTL_SEL_LSB = 2;

  // Channel driven for a slot: in select mode, the low slots repeat
  // the chosen channel; otherwise each slot converts its own channel.
  function automatic int unsigned slot_chan(input int unsigned slot,
                                            input logic        sel_mode,
                                            input int unsigned sel,
                                            input int unsigned num_sel);
    return (sel_mode && (slot < num_sel)) ? sel : slot;
  endfunction

endpackage

// File: rtl/adcseq_trig.sv
// Samples the trigger pin on machine-cycle ticks and flags a high-to-low
// change between two consecutive samples.
module adcseq_trig (
  input  logic clk,
  input  logic rst,
  input  logic mc_tick,
  input  logic pin,
  output logic fall
);

  logic smp_q;

  always_ff @(posedge clk) begin
    if (rst)          smp_q <= 1'b0;
    else if (mc_tick) smp_q <= pin;
  end

  assign fall = mc_tick && smp_q && !pin;

endmodule

// File: rtl/adcseq_fsm.sv
// Slot sequencer: issues start pulses, accepts done pulses, and steps
// through the slots of a conversion cycle.
module adcseq_fsm
  import adcseq_pkg::*;
#(
  parameter  int N_SLOTS = 8,
  parameter  int NUM_SEL = 4,
  localparam int IDX_W   = $clog2(N_SLOTS),
  localparam int SEL_W   = $clog2(NUM_SEL)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             ext,
  input  logic             sel_mode,
  input  logic [SEL_W-1:0] sel,
  input  logic             mc_tick,
  input  logic             fall,
  input  logic             conv_done,
  output logic             conv_start,
  output logic [IDX_W-1:0] conv_chan,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_idx,
  output logic             last_done
);

  localparam logic [IDX_W-1:0] LAST  = IDX_W'(N_SLOTS - 1);
  localparam logic [IDX_W-1:0] UPPER = IDX_W'(NUM_SEL);

  logic [IDX_W-1:0] slot_q;
  logic [IDX_W-1:0] slot_nxt;
  logic             busy_q;
  logic             pend_q;
  logic             done_ok;
  logic             go_int;
  logic             go_ext;

  assign slot_nxt  = slot_q + 1'b1;
  assign done_ok   = busy_q && en && conv_done && !conv_start;
  assign last_done = done_ok && (slot_q == LAST);
  assign wr_en     = done_ok;
  assign wr_idx    = slot_q;
  assign go_int    = !busy_q && en && !ext && mc_tick;
  assign go_ext    = !busy_q && en && ext && pend_q && mc_tick;

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_q     <= '0;
      busy_q     <= 1'b0;
      pend_q     <= 1'b0;
      conv_start <= 1'b0;
      conv_chan  <= '0;
    end else begin
      conv_start <= 1'b0;
      if (!en) begin
        busy_q <= 1'b0;
        pend_q <= 1'b0;
      end else begin
        if (!ext) pend_q <= 1'b0;
        else if (!busy_q && fall && !pend_q) pend_q <= 1'b1;
        if (go_int || go_ext) begin
          busy_q     <= 1'b1;
          pend_q     <= 1'b0;
          slot_q     <= '0;
          conv_start <= 1'b1;
          conv_chan  <= IDX_W'(slot_chan(0, sel_mode, 32'(sel), NUM_SEL));
        end else if (done_ok) begin
          if (slot_q != LAST) begin
            slot_q     <= slot_nxt;
            conv_start <= 1'b1;
            conv_chan  <= IDX_W'(slot_chan(32'(slot_nxt), sel_mode, 32'(sel), NUM_SEL));
          end else if (!ext) begin
            slot_q     <= '0;
            conv_start <= 1'b1;
            conv_chan  <= IDX_W'(slot_chan(0, sel_mode, 32'(sel), NUM_SEL));
          end else begin
            busy_q <= 1'b0;
          end
        end
      end
    end
  end

  AST_START_SINGLE: assert property (@(posedge clk) disable iff (rst)
    conv_start |=> !conv_start);                                    // R2
  AST_OFF_NO_START: assert property (@(posedge clk) disable iff (rst)
    !en |=> !conv_start);                                           // R3
  AST_EXT_HALTED: assert property (@(posedge clk) disable iff (rst)
    (ext && !busy_q && !pend_q) |=> !conv_start);                   // R5
  AST_BUSY_NO_PEND: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> !pend_q);                                            // R6
  AST_UPPER_OWN_CHAN: assert property (@(posedge clk) disable iff (rst)
    (conv_start && slot_q >= UPPER) |-> (conv_chan == slot_q));     // R8

endmodule

// File: rtl/adcseq_store.sv
// Result registers (inferable as RAM, registered read) and compare bits.
module adcseq_store #(
  parameter  int N_SLOTS = 8,
  parameter  int RES_W   = 10,
  localparam int IDX_W   = $clog2(N_SLOTS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [RES_W-1:0]   wr_data,
  input  logic               wr_gt,
  input  logic [IDX_W-1:0]   rd_idx,
  output logic [RES_W-1:0]   rd_data,
  output logic [N_SLOTS-1:0] cmp_bits
);

  logic [RES_W-1:0] mem [N_SLOTS];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
    rd_data <= mem[rd_idx];
  end

  always_ff @(posedge clk) begin
    if (rst)        cmp_bits         <= '0;
    else if (wr_en) cmp_bits[wr_idx] <= wr_gt;
  end

  AST_CMP_HOLD: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(cmp_bits));                                  // R10

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adcseq_pkg::*;
#(
  parameter  int N_SLOTS = 8,
  parameter  int RES_W   = 10,
  parameter  int NUM_SEL = 4,
  localparam int IDX_W   = $clog2(N_SLOTS),
  localparam int SEL_W   = $clog2(NUM_SEL),
  localparam int CTL_W   = CTL_SEL_LSB + SEL_W + 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               mc_tick,
  input  logic               ctl_wr,
  input  logic [CTL_W-1:0]   ctl_wdata,
  output logic [CTL_W-1:0]   ctl_rdata,
  input  logic               irq_en,
  output logic               irq,
  input  logic               trig_pin,
  output logic               conv_start,
  output logic [IDX_W-1:0]   conv_chan,
  input  logic               conv_done,
  input  logic [RES_W-1:0]   conv_data,
  input  logic               conv_gt,
  input  logic [IDX_W-1:0]   rd_idx,
  output logic [RES_W-1:0]   rd_data,
  output logic [N_SLOTS-1:0] cmp_bits
);

  localparam int MODE_BIT = CTL_SEL_LSB + SEL_W;
  localparam int EXT_BIT  = MODE_BIT + 1;

  logic [CTL_W-1:0] ctl_q;
  logic             flag_d;
  logic             fall;
  logic             wr_en;
  logic [IDX_W-1:0] wr_idx;
  logic             last_done;

  // The hardware set wins over a software clear in the same cycle; a
  // write can only lower the flag.
  assign flag_d = last_done ||
                  (ctl_q[CTL_FLAG] && !(ctl_wr && !ctl_wdata[CTL_FLAG]));

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q <= '0;
      irq   <= 1'b0;
    end else begin
      if (ctl_wr) ctl_q <= ctl_wdata;
      ctl_q[CTL_FLAG] <= flag_d;
      irq             <= flag_d && irq_en;
    end
  end

  assign ctl_rdata = ctl_q;

  adcseq_trig u_trig (
    .clk     (clk),
    .rst     (rst),
    .mc_tick (mc_tick),
    .pin     (trig_pin),
    .fall    (fall)
  );

  adcseq_fsm #(.N_SLOTS(N_SLOTS), .NUM_SEL(NUM_SEL)) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .en         (ctl_q[CTL_EN]),
    .ext        (ctl_q[EXT_BIT]),
    .sel_mode   (ctl_q[MODE_BIT]),
    .sel        (ctl_q[CTL_SEL_LSB +: SEL_W]),
    .mc_tick    (mc_tick),
    .fall       (fall),
    .conv_done  (conv_done),
    .conv_start (conv_start),
    .conv_chan  (conv_chan),
    .wr_en      (wr_en),
    .wr_idx     (wr_idx),
    .last_done  (last_done)
  );

  adcseq_store #(.N_SLOTS(N_SLOTS), .RES_W(RES_W)) u_store (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .wr_data  (conv_data),
    .wr_gt    (conv_gt),
    .rd_idx   (rd_idx),
    .rd_data  (rd_data),
    .cmp_bits (cmp_bits)
  );

  AST_FLAG_FROM_DONE: assert property (@(posedge clk) disable iff (rst)
    $rose(ctl_q[CTL_FLAG]) |-> $past(conv_done));                   // R9

endmodule

// File: tb/sim_adc_seq_ctrl.sv
module sim_adc_seq_ctrl;
  localparam int N   = 8;
  localparam int RW  = 10;
  localparam int LAT = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic          mc_tick = 1'b0;
  logic [1:0]    tdiv = '0;
  logic          ctl_wr = 1'b0;
  logic [5:0]    ctl_wdata = '0;
  logic [5:0]    ctl_rdata;
  logic          irq_en = 1'b0;
  logic          irq;
  logic          trig_pin = 1'b1;
  logic          conv_start;
  logic [2:0]    conv_chan;
  logic          conv_done = 1'b0;
  logic [RW-1:0] conv_data = '0;
  logic          conv_gt = 1'b0;
  logic [2:0]    rd_idx = '0;
  logic [RW-1:0] rd_data;
  logic [N-1:0]  cmp_bits;

  adc_seq_ctrl u0 (
    .clk(clk), .rst(rst), .mc_tick(mc_tick), .ctl_wr(ctl_wr),
    .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata), .irq_en(irq_en),
    .irq(irq), .trig_pin(trig_pin), .conv_start(conv_start),
    .conv_chan(conv_chan), .conv_done(conv_done), .conv_data(conv_data),
    .conv_gt(conv_gt), .rd_idx(rd_idx), .rd_data(rd_data),
    .cmp_bits(cmp_bits)
  );

  // Machine-cycle tick: one clock in four.
  always @(posedge clk) begin
    tdiv    <= tdiv + 2'd1;
    mc_tick <= (tdiv == 2'd3);
  end

  // Behavioural converter and comparator.
  logic [RW-1:0] ain [N];
  logic [RW-1:0] thr = '0;
  logic [2:0]    cch = '0;
  logic [2:0]    seq_log [64];
  int            cnt = 0;
  int            n_starts = 0;

  always @(posedge clk) begin
    conv_done <= 1'b0;
    if (conv_start) begin
      cch                    <= conv_chan;
      cnt                    <= LAT;
      seq_log[n_starts % 64] <= conv_chan;
      n_starts               <= n_starts + 1;
    end else if (cnt > 0) begin
      cnt <= cnt - 1;
      if (cnt == 1) begin
        conv_done <= 1'b1;
        conv_data <= ain[cch];
        conv_gt   <= (ain[cch] > thr);
      end
    end
  end

  int n_chk  = 0;
  int n_fail = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_ctl(input logic [5:0] v);
    @(negedge clk);
    ctl_wr    = 1'b1;
    ctl_wdata = v;
    @(negedge clk);
    ctl_wr    = 1'b0;
  endtask

  task automatic wait_flag(input string req);
    int k = 0;
    while (k < 3000 && !ctl_rdata[0]) begin
      k++;
      @(negedge clk);
    end
    chk(req, 32'(ctl_rdata[0]), 1);
  endtask

  task automatic rd(input int i, output logic [RW-1:0] v);
    @(negedge clk);
    rd_idx = 3'(i);
    @(negedge clk);
    v = rd_data;
  endtask

  function automatic int exp_chan(input int slot, input bit mode, input int sel);
    return (mode && slot < 4) ? sel : slot;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [RW-1:0] v;
    logic [N-1:0]  ecmp;
    int            base;
    bit            ok_pre;

    idle(4);
    rst = 1'b0;
    idle(2);
    // R1 reset state
    chk("R1 ctl after reset", 32'(ctl_rdata), 0);
    chk("R1 cmp after reset", 32'(cmp_bits), 0);
    chk("R1 irq after reset", 32'(irq), 0);
    chk("R1 start after reset", 32'(conv_start), 0);

    // R12 writing 1 to the flag does not set it
    wr_ctl(6'b000001);
    idle(1);
    chk("R12 write one keeps flag clear", 32'(ctl_rdata[0]), 0);
    wr_ctl(6'b000000);

    // Internal scan: R2, R7, R9, R10
    for (int i = 0; i < N; i++) ain[i] = RW'(i * 97 + 13);
    thr    = 10'd300;
    irq_en = 1'b1;
    base   = n_starts;
    wr_ctl(6'b000010);
    ok_pre = 1'b1;
    while (!mc_tick) begin
      if (conv_start) ok_pre = 1'b0;
      @(negedge clk);
    end
    chk("R2 no start before first tick", 32'(ok_pre), 1);
    @(negedge clk);
    chk("R2 start after first tick", 32'(conv_start), 1);
    chk("R7 first slot channel", 32'(conv_chan), 0);
    wait_flag("R9 flag after slot 7");
    idle(2);
    chk("R9 irq with enable", 32'(irq), 1);
    for (int i = 0; i < N; i++)
      chk($sformatf("R7 scan order slot %0d", i), 32'(seq_log[(base + i) % 64]), i);
    while (n_starts < base + 9) @(negedge clk);
    chk("R2 free-running restart at slot 0", 32'(seq_log[(base + 8) % 64]), 0);
    wr_ctl(6'b000000);
    chk("R12 write zero clears flag", 32'(ctl_rdata), 0);
    idle(30);
    base = n_starts;
    idle(60);
    chk("R3 no start after disable", n_starts, base);
    ecmp = '0;
    for (int i = 0; i < N; i++) begin
      ecmp[i] = (ain[i] > thr);
      rd(i, v);
      chk($sformatf("R7 result slot %0d", i), 32'(v), 32'(ain[i]));
    end
    chk("R10 compare bits scan", 32'(cmp_bits), 32'(ecmp));

    // R3 discard of a pending done, then R11 overwrite
    for (int i = 0; i < N; i++) ain[i] = RW'(i * 53 + 200);
    base = n_starts;
    wr_ctl(6'b000010);
    while (n_starts < base + 1) @(negedge clk);
    wr_ctl(6'b000000);
    idle(30);
    rd(0, v);
    chk("R3 discarded done leaves result", 32'(v), 13);
    wr_ctl(6'b000010);
    wait_flag("R11 second cycle flag");
    wr_ctl(6'b000000);
    idle(30);
    ecmp = '0;
    for (int i = 0; i < N; i++) begin
      ecmp[i] = (ain[i] > thr);
      rd(i, v);
      chk($sformatf("R11 overwritten slot %0d", i), 32'(v), 32'(ain[i]));
    end
    chk("R10 compare bits after overwrite", 32'(cmp_bits), 32'(ecmp));

    // External trigger, select mode sweep: R5, R6, R8, R9
    trig_pin = 1'b1;
    for (int s = 0; s < 4; s++) begin
      for (int i = 0; i < N; i++) ain[i] = RW'(i * 41 + s * 70 + 5);
      thr    = 10'd250;
      irq_en = (s != 3);
      wr_ctl(6'({1'b1, 1'b1, 2'(s), 1'b1, 1'b0}));
      idle(12);
      base = n_starts;
      chk("R5 idle before edge", n_starts, base);
      trig_pin = 1'b0;
      if (s == 1) begin
        while (n_starts < base + 3) @(negedge clk);
        trig_pin = 1'b1;
        idle(10);
        trig_pin = 1'b0;
      end
      wait_flag($sformatf("R9 flag select %0d", s));
      idle(60);
      chk(s == 1 ? "R6 mid-cycle edge ignored" : "R5 exactly one cycle",
          n_starts - base, 8);
      if (s == 3) chk("R9 irq masked", 32'(irq), 0);
      ecmp = '0;
      for (int i = 0; i < N; i++) begin
        chk($sformatf("R8 channel sel %0d slot %0d", s, i),
            32'(seq_log[(base + i) % 64]), exp_chan(i, 1'b1, s));
        ecmp[i] = (ain[exp_chan(i, 1'b1, s)] > thr);
        rd(i, v);
        chk($sformatf("R8 result sel %0d slot %0d", s, i),
            32'(v), 32'(ain[exp_chan(i, 1'b1, s)]));
      end
      chk($sformatf("R10 compare bits sel %0d", s), 32'(cmp_bits), 32'(ecmp));
      trig_pin = 1'b1;
      idle(4);
    end

    // R4: a low glitch between ticks is not an edge
    wr_ctl(6'b100010);
    idle(12);
    base = n_starts;
    while (!mc_tick) @(negedge clk);
    @(negedge clk);
    trig_pin = 1'b0;
    @(negedge clk);
    trig_pin = 1'b1;
    idle(40);
    chk("R4 glitch between ticks ignored", n_starts, base);

    // R4: an edge while disabled is ignored
    wr_ctl(6'b100000);
    idle(12);
    trig_pin = 1'b0;
    idle(40);
    chk("R4 edge with enable low ignored", n_starts, base);
    wr_ctl(6'b100010);
    idle(40);
    chk("R4 stale low level not an edge", n_starts, base);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule